// File: doc/BRIEF.md
# Three-Channel Interleaved FIR Filter

This block is a fully parallel, pipelined FIR filter that serves several channels over one valid/ready stream, three by default. Samples arrive interleaved, one channel after another. A start-of-packet marker opens each round of channels, and an end-of-packet marker closes it. Every channel has its own delay line, so the channels never mix. The block can take one sample and produce one filtered result on every clock. Each result carries its channel number and the start and end markers of the round it belongs to.

The coefficients are fixed signed constants, supplied as a packed parameter. The accumulator keeps full precision. Its width is the sample width plus the coefficient width plus ceil(log2 of the tap count), and the output is that full value.

Back-pressure rules: a sample moves on a rising edge only when `snk_valid` and `snk_ready` are both high. `snk_ready` is a direct copy of `src_ready`. While `src_ready` is low, every pipeline stage holds its contents. A result that is already on `src_valid` then stays unchanged until it is taken, and nothing is lost. `src_valid` does not wait for `src_ready`.

Top module: `mcfir_top`

## Requirements
- R1: A sample is taken only on a rising edge where `snk_valid` and `snk_ready` are both high, and `snk_ready` always equals `src_ready`. A result leaves only on an edge where `src_valid` and `src_ready` are both high.
- R2: With `snk_valid` and `src_ready` held high, one result leaves on every clock. A sample taken on edge E shows on the outputs after edge E+2, so it is visible in the third cycle after it was presented.
- R3: A taken sample with `snk_sop` high belongs to channel 0. Any other taken sample belongs to the channel after the previous one. Channel numbers run 0 to CHANNELS-1.
- R4: The result for a sample of channel c equals the sum over k of COEFS[k] times the k-th most recent sample of channel c, counting that sample as k=0. Coefficient k sits in bits [k*CW +: CW] of COEFS, and samples and coefficients are two's complement. Only channel c's delay line shifts.
- R5: `src_channel` gives the channel of each result. `src_sop` is high exactly when that channel is 0. `src_eop` is high when the channel is CHANNELS-1, or when the sample that produced the result had `snk_eop` high.
- R6: While `src_ready` is low, `src_valid`, `src_data`, `src_channel`, `src_sop` and `src_eop` hold their values. Every taken sample later produces exactly one result, in order.
- R7: `src_data` is the exact signed sum, with width DW+CW+ceil(log2 TAPS). It does not wrap, even for full-scale inputs of either sign.
- R8: While `rst_n` is low, `src_valid` is low. After reset every delay line reads as zero, and the channel count restarts at 0.
- R9: A taken sample with `snk_eop` high makes the next sample belong to channel 0, even if the round was short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| snk_valid | input | 1 | Input sample present |
| snk_ready | output | 1 | Filter can take a sample (copy of `src_ready`) |
| snk_data | input | DW | Signed input sample |
| snk_sop | input | 1 | Sample opens a round (channel 0) |
| snk_eop | input | 1 | Sample closes a round |
| src_valid | output | 1 | Result present |
| src_ready | input | 1 | Downstream can take a result |
| src_data | output | DW+CW+clog2(TAPS) | Signed full-precision result |
| src_channel | output | max(1,clog2(CHANNELS)) | Channel of the result |
| src_sop | output | 1 | Result is for channel 0 |
| src_eop | output | 1 | Result closes a round |

## Verification
The hardest case to reach is back-pressure that arrives while rounds are misframed. A stall has to freeze a result whose channel tag came from a resynchronising start or end marker, and the delay lines of the other channels have to stay untouched through it. The random phase lets valid and ready toggle on their own. It also injects stray `snk_sop` and early `snk_eop` markers now and then, so stalls land on every pipeline stage while the channel count is being forced back to 0. Directed runs add a back-to-back stream, alternating full-scale inputs that drive the accumulator to its largest sums, and a reset in the middle of traffic.

// File: rtl/mcfir_pkg.sv
package mcfir_pkg;

  function automatic int clog2_min1(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int acc_width(input int dw, input int cw, input int taps);
    int g;
    g = 0;
    while ((1 << g) < taps) g++;
    return dw + cw + g;
  endfunction

endpackage

// File: rtl/mcfir_framer.sv
module mcfir_framer #(
  parameter int CHANNELS = 3,
  parameter int CHW      = 2,
  parameter int LAT      = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           accept,
  input  logic           in_sop,
  input  logic           in_eop,
  output logic [CHW-1:0] cur_chan,
  output logic           out_valid,
  output logic [CHW-1:0] out_chan,
  output logic           out_sop,
  output logic           out_eop
);
  localparam logic [CHW-1:0] LAST_CH = CHW'(CHANNELS - 1);

  logic [CHW-1:0] cnt_q;
  logic           is_last;

  logic [LAT-1:0]          v_q;
  logic [LAT-1:0][CHW-1:0] ch_q;
  logic [LAT-1:0]          sop_q;
  logic [LAT-1:0]          eop_q;

  // start marker forces channel 0
  assign cur_chan = in_sop ? '0 : cnt_q;
  assign is_last  = (cur_chan == LAST_CH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= (in_eop || is_last) ? '0 : cur_chan + CHW'(1);
    end
  end

  // first tag stage, aligned with the window register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q[0]   <= 1'b0;
      ch_q[0]  <= '0;
      sop_q[0] <= 1'b0;
      eop_q[0] <= 1'b0;
    end else if (en) begin
      v_q[0]   <= accept;
      ch_q[0]  <= cur_chan;
      sop_q[0] <= (cur_chan == '0);
      eop_q[0] <= in_eop || is_last;
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s]   <= 1'b0;
        ch_q[s]  <= '0;
        sop_q[s] <= 1'b0;
        eop_q[s] <= 1'b0;
      end else if (en) begin
        v_q[s]   <= v_q[s-1];
        ch_q[s]  <= ch_q[s-1];
        sop_q[s] <= sop_q[s-1];
        eop_q[s] <= eop_q[s-1];
      end
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_chan  = ch_q[LAT-1];
  assign out_sop   = sop_q[LAT-1];
  assign out_eop   = eop_q[LAT-1];

  // R3: counter never leaves the channel range
  assert_chan_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CH);

  // R3: a start marker lands on channel 0
  assert_sop_resync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_sop) |=> (ch_q[0] == '0 && sop_q[0]));

  // R9: an end marker restarts the round
  assert_eop_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_eop) |=> (cnt_q == '0));

endmodule

// File: rtl/mcfir_delay_bank.sv
module mcfir_delay_bank #(
  parameter int CHANNELS = 3,
  parameter int CHW      = 2,
  parameter int TAPS     = 4,
  parameter int DW       = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic [CHW-1:0]           chan,
  input  logic [DW-1:0]            sample,
  output logic [TAPS-1:0][DW-1:0]  win
);
  // index 0 of each line is the newest sample
  logic [CHANNELS-1:0][TAPS-1:0][DW-1:0] line_q;
  logic [TAPS-1:0][DW-1:0]               shifted;
  logic [TAPS-1:0][DW-1:0]               sel_line;

  always_comb begin
    sel_line = '0;
    for (int c = 0; c < CHANNELS; c++) begin
      if (chan == CHW'(c)) sel_line = line_q[c];
    end
  end

  always_comb begin
    shifted[0] = sample;
    for (int k = 1; k < TAPS; k++) shifted[k] = sel_line[k-1];
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[c] <= '0;
      end else if (accept && chan == CHW'(c)) begin
        line_q[c] <= shifted;
      end
    end

    // R4: lines of other channels do not move
    assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && chan == CHW'(c)) |=> $stable(line_q[c]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
    end else if (accept) begin
      win <= shifted;
    end
  end

endmodule

// File: rtl/mcfir_mac.sv
module mcfir_mac #(
  parameter int               TAPS  = 4,
  parameter int               DW    = 12,
  parameter int               CW    = 8,
  parameter int               AW    = 22,
  parameter logic [TAPS*CW-1:0] COEFS = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [TAPS-1:0][DW-1:0] win,
  output logic [AW-1:0]           acc
);
  localparam int PW = DW + CW;

  function automatic longint coef_abs_sum();
    longint s;
    longint v;
    s = 0;
    for (int k = 0; k < TAPS; k++) begin
      v = longint'($signed(COEFS[k*CW +: CW]));
      s += (v < 0) ? -v : v;
    end
    return s;
  endfunction

  localparam longint BOUND = coef_abs_sum() * (longint'(1) << (DW - 1));

  logic [TAPS-1:0][PW-1:0] prod_q;
  logic signed [AW-1:0]    sum;

  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    localparam logic signed [CW-1:0] CK = COEFS[k*CW +: CW];
    logic signed [PW-1:0] xs;
    logic signed [PW-1:0] cs;
    assign xs = PW'($signed(win[k]));
    assign cs = PW'(CK);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q[k] <= '0;
      end else if (en) begin
        prod_q[k] <= xs * cs;
      end
    end
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < TAPS; k++) sum += AW'($signed(prod_q[k]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (en) begin
      acc <= sum;
    end
  end

  // R7: the sum stays inside the reachable range, so the width never wraps
  assert_acc_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (longint'($signed(acc)) <= BOUND) && (longint'($signed(acc)) >= -BOUND));

endmodule

// File: rtl/mcfir_top.sv
module mcfir_top
  import mcfir_pkg::*;
#(
  parameter int                 CHANNELS = 3,
  parameter int                 TAPS     = 4,
  parameter int                 DW       = 12,
  parameter int                 CW       = 8,
  parameter logic [TAPS*CW-1:0] COEFS    = {8'h80, 8'h07, 8'hFD, 8'h05},
  localparam int                AW       = acc_width(DW, CW, TAPS),
  localparam int                CHW      = clog2_min1(CHANNELS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           snk_valid,
  output logic           snk_ready,
  input  logic [DW-1:0]  snk_data,
  input  logic           snk_sop,
  input  logic           snk_eop,
  output logic           src_valid,
  input  logic           src_ready,
  output logic [AW-1:0]  src_data,
  output logic [CHW-1:0] src_channel,
  output logic           src_sop,
  output logic           src_eop
);
  localparam int LAT = 3;

  logic                    en;
  logic                    accept;
  logic [CHW-1:0]          cur_chan;
  logic [TAPS-1:0][DW-1:0] win;

  assign en        = src_ready;
  assign snk_ready = src_ready;
  assign accept    = snk_valid && src_ready;

  mcfir_framer #(
    .CHANNELS(CHANNELS),
    .CHW     (CHW),
    .LAT     (LAT)
  ) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .accept   (accept),
    .in_sop   (snk_sop),
    .in_eop   (snk_eop),
    .cur_chan (cur_chan),
    .out_valid(src_valid),
    .out_chan (src_channel),
    .out_sop  (src_sop),
    .out_eop  (src_eop)
  );

  mcfir_delay_bank #(
    .CHANNELS(CHANNELS),
    .CHW     (CHW),
    .TAPS    (TAPS),
    .DW      (DW)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .accept(accept),
    .chan  (cur_chan),
    .sample(snk_data),
    .win   (win)
  );

  mcfir_mac #(
    .TAPS (TAPS),
    .DW   (DW),
    .CW   (CW),
    .AW   (AW),
    .COEFS(COEFS)
  ) u_mac (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .win  (win),
    .acc  (src_data)
  );

  // R6: a result waiting on back-pressure holds still
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !src_ready) |=> (src_valid && $stable(src_data) &&
      $stable(src_channel) && $stable(src_sop) && $stable(src_eop)));

  // R1: no sample is taken while the output side stalls
  assert_no_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !src_ready |=> $stable(cur_chan) || $past(snk_sop) != snk_sop);

endmodule

// File: tb/mcfir_top_tb.sv
module mcfir_top_tb;
  localparam int CH   = 3;
  localparam int TAPS = 4;
  localparam int DW   = 12;
  localparam int AW   = 22;
  localparam int CHW  = 2;

  int coef [TAPS] = '{5, -3, 7, -128};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           snk_valid = 1'b0;
  logic           snk_ready;
  logic [DW-1:0]  snk_data = '0;
  logic           snk_sop = 1'b0;
  logic           snk_eop = 1'b0;
  logic           src_valid;
  logic           src_ready = 1'b0;
  logic [AW-1:0]  src_data;
  logic [CHW-1:0] src_channel;
  logic           src_sop;
  logic           src_eop;

  always #5 clk = ~clk;

  mcfir_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
    .snk_sop(snk_sop), .snk_eop(snk_eop),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .src_channel(src_channel), .src_sop(src_sop), .src_eop(src_eop)
  );

  typedef struct { int y; int ch; bit sop; bit eop; } res_t;

  int   hist [CH][TAPS];
  int   cnt_m;
  res_t expq [$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   prev_stall = 0;
  logic [AW-1:0] prev_data;
  int   pops = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fir_out(input int c);
    int s = 0;
    for (int k = 0; k < TAPS; k++) s += coef[k] * hist[c][k];
    return s;
  endfunction

  function automatic void model_take(input bit sop, input bit eop, input int x);
    int  cur;
    bit  last;
    res_t r;
    cur = sop ? 0 : cnt_m;
    for (int k = TAPS - 1; k > 0; k--) hist[cur][k] = hist[cur][k-1];
    hist[cur][0] = x;
    last = (cur == CH - 1);
    r.y = fir_out(cur); r.ch = cur; r.sop = (cur == 0); r.eop = eop || last;
    expq.push_back(r);
    cnt_m = (eop || last) ? 0 : cur + 1;
  endfunction

  function automatic void model_clear();
    for (int c = 0; c < CH; c++)
      for (int k = 0; k < TAPS; k++) hist[c][k] = 0;
    cnt_m = 0;
    expq.delete();
  endfunction

  task automatic step(input bit v, input bit sop, input bit eop, input int x, input bit rdy);
    res_t r;
    @(negedge clk);
    snk_valid = v; snk_sop = sop; snk_eop = eop; snk_data = DW'(x); src_ready = rdy;
    #1;
    chk(snk_ready == rdy, "R1", "snk_ready follows src_ready", longint'(snk_ready), longint'(rdy));
    if (prev_stall)
      chk(src_valid && src_data == prev_data, "R6", "held result",
          longint'($signed(src_data)), longint'($signed(prev_data)));
    if (src_valid && rdy) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R1", "result without a sample", 1, 0);
      end else begin
        r = expq.pop_front();
        pops++;
        chk(int'($signed(src_data)) == r.y, "R4 R7", "data",
            longint'($signed(src_data)), longint'(r.y));
        chk(int'(src_channel) == r.ch, "R3 R9", "channel", longint'(src_channel), longint'(r.ch));
        chk(src_sop == r.sop && src_eop == r.eop, "R5", "sop/eop",
            longint'({src_sop, src_eop}), longint'({r.sop, r.eop}));
      end
    end
    prev_stall = src_valid && !rdy;
    prev_data  = src_data;
    if (v && rdy) model_take(sop, eop, x);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; snk_valid = 1'b0; src_ready = 1'b1;
    model_clear();
    prev_stall = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(src_valid == 1'b0, "R8", "src_valid low in reset", longint'(src_valid), 0);
    rst_n = 1'b1;
  endtask

  function automatic int rand_sample();
    int p = $urandom_range(0, 19);
    if (p == 0) return -2048;
    if (p == 1) return 2047;
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int sv;
    bit sop;
    bit eop;
    void'($urandom(32'd1234));
    model_clear();
    do_reset();

    // R2: latency of one sample into an idle pipeline
    step(1'b1, 1'b1, 1'b0, 100, 1'b1);
    step(1'b0, 1'b0, 1'b0, 0, 1'b1);
    chk(src_valid == 1'b0, "R2", "not yet valid after 1", longint'(src_valid), 0);
    step(1'b0, 1'b0, 1'b0, 0, 1'b1);
    chk(src_valid == 1'b0, "R2", "not yet valid after 2", longint'(src_valid), 0);
    step(1'b0, 1'b0, 1'b0, 0, 1'b1);
    chk(pops == 1, "R2", "result in third cycle", longint'(pops), 1);

    // R2: back-to-back stream
    for (int i = 0; i < 60; i++) begin
      step(1'b1, cnt_m == 0, cnt_m == CH - 1, rand_sample(), 1'b1);
      if (i >= 3) chk(src_valid == 1'b1, "R2", "one result per clock", longint'(src_valid), 1);
    end

    // R7: alternating full scale to reach the largest sums
    for (int i = 0; i < 8 * CH; i++) begin
      sv = ((i / CH) % 2 == 0) ? 2047 : -2048;
      step(1'b1, cnt_m == 0, cnt_m == CH - 1, sv, 1'b1);
    end
    for (int i = 0; i < 4 * CH; i++) step(1'b1, cnt_m == 0, cnt_m == CH - 1, -2048, 1'b1);

    // R3 R9: short rounds closed by an early end marker
    step(1'b1, 1'b1, 1'b1, 33, 1'b1);
    step(1'b1, 1'b0, 1'b0, 44, 1'b1);
    step(1'b1, 1'b1, 1'b0, 55, 1'b1);
    step(1'b1, 1'b0, 1'b1, 66, 1'b1);
    step(1'b1, 1'b0, 1'b0, 77, 1'b1);

    // random traffic with stalls and framing faults
    for (int i = 0; i < 4000; i++) begin
      sop = (cnt_m == 0) || ($urandom_range(0, 49) == 0);
      eop = (cnt_m == CH - 1) || ($urandom_range(0, 49) == 0);
      step($urandom_range(0, 4) != 0, sop, eop, rand_sample(), $urandom_range(0, 3) != 0);
    end

    // R8: reset in the middle of traffic, then zero history
    do_reset();
    for (int i = 0; i < 30; i++) step(1'b1, cnt_m == 0, cnt_m == CH - 1, rand_sample(), 1'b1);

    // R6: drain, nothing lost
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, 0, 1'b1);
    chk(expq.size() == 0, "R6", "all results delivered", longint'(expq.size()), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule